// File: doc/BRIEF.md
# Four-Way Cache Tag Controller

This block holds the tags, line state and line data of a four-way set-associative data cache, and it decides where new lines go. A single request port accepts four operations: read, write, fill and push. Each accepted operation gets a registered response one cycle later. The response says whether the address was present and in which way. For a read it also returns the addressed 32-bit word.

Fills go to the lowest-numbered empty way of the indexed set. When the set has no empty way, a per-set round-robin pointer picks the victim. If the line leaving the cache is modified, its line address and data appear on a write-back output, and the surrounding logic carries out the memory transfer.

Reset does not touch the line-state arrays. The owner must issue an invalidate-all command before using the cache. That command walks every set, one per cycle, and stalls the request port while it runs.

Top module: `dcache_tag_ctrl`

## Requirements
- R1: An invalidate-all pulse accepted while idle raises `busy_o` on the next cycle. `busy_o` stays high for exactly SETS cycles. When it falls, every line is invalid and every round-robin pointer is 0.
- R2: A request is ignored when it arrives while `busy_o` is high or in the same cycle as `inv_all_i`. An ignored request gives no `resp_valid_o` and no `wb_valid_o`.
- R3: Every accepted request gives `resp_valid_o` exactly one cycle later. A read (`req_op_i`=00) of a present line returns hit=1, the way, and the word selected by address bits [3:2]. A read of an absent line returns hit=0.
- R4: A write (`req_op_i`=01) that hits replaces the addressed word and marks the line modified. A write that misses changes no line.
- R5: A fill (`req_op_i`=10) of an absent address takes the lowest-numbered invalid way of the set. The new line is valid and clean, and `resp_way_o` reports the chosen way.
- R6: When all ways of a set are valid, a fill of an absent address replaces the way named by that set's round-robin pointer. The pointer then advances by one, modulo four.
- R7: When a fill replaces a modified line, `wb_valid_o` pulses in the response cycle. `wb_addr_o` then carries {old tag, index, 4'b0000} and `wb_line_o` carries the old data, with word 0 in the low bits. Replacing a clean line or an invalid line gives no write-back.
- R8: A push (`req_op_i`=11) names a way through `req_way_i` and a set through the address index. A push of a modified line pulses a write-back of that line and leaves it invalid and clean. A push of a clean line invalidates it without a write-back. A push of an invalid line has no effect.
- R9: A fill of an address that is already present reuses that way, reports hit=1, leaves the line clean and gives no write-back.
- R10: An invalid line never hits, whatever its modified bit holds.
- R11: Reset clears `busy_o`, `resp_valid_o` and `wb_valid_o`, and it leaves tags, state and data unchanged. A line filled before the reset still hits after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all_i | input | 1 | Start the invalidate-all sweep |
| busy_o | output | 1 | Sweep in progress; requests are ignored |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 00 read, 01 write, 10 fill, 11 push |
| req_addr_i | input | TAG_W+log2(SETS)+4 | Byte address: tag, index, word, byte |
| req_way_i | input | log2(WAYS) | Way targeted by a push |
| req_wdata_i | input | DW | Write data |
| req_line_i | input | WORDS*DW | Fill line data, word 0 in the low bits |
| resp_valid_o | output | 1 | Response for the request of the previous cycle |
| resp_hit_o | output | 1 | Address present (for a push: the line was valid) |
| resp_way_o | output | log2(WAYS) | Hit, filled or pushed way |
| resp_rdata_o | output | DW | Read word |
| wb_valid_o | output | 1 | Modified line leaving the cache |
| wb_addr_o | output | TAG_W+log2(SETS)+4 | Line address of the leaving line |
| wb_line_o | output | WORDS*DW | Data of the leaving line |

## Verification
The bench uses an eight-set configuration. It fills every way of every set with distinct tags and reads back every word, which separates errors in way choice, index decode and word select. Writes that land on one way per set and writes that miss separate a correct hit update from stray updates. Five further fills per full set walk the round-robin pointer through a whole turn, so each replacement reports either a write-back of a modified line or none for a clean one. Pushes of modified, clean and invalid lines, a refill of a present address, a request issued during the sweep, and a reset in the middle of use each exercise one of the corner rules on their own.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FILL  = 2'b10,
    OP_PUSH  = 2'b11
  } dct_op_e;
endpackage

// File: rtl/dct_sweep.sv
module dct_sweep #(
  parameter int SETS = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic [$clog2(SETS)-1:0]   idx_o
);
  localparam int IW = $clog2(SETS);
  localparam logic [IW-1:0] LAST = IW'(SETS - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + IW'(1);
    end else if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  // R1: the sweep covers every set and then releases the port
  a_r1_sweep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != LAST) |=> busy_q);
  a_r1_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == LAST) |=> !busy_q);
endmodule

// File: rtl/dct_match.sv
module dct_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 21
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [$clog2(WAYS)-1:0]    way_o
);
  localparam int WW = $clog2(WAYS);

  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hv[i]) way_o = WW'(i);
    end
  end

  assign hit_o = |hv;
endmodule

// File: rtl/dct_victim.sv
module dct_victim #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]         valid_i,
  input  logic [$clog2(WAYS)-1:0] rr_i,
  output logic                    free_o,
  output logic [$clog2(WAYS)-1:0] way_o
);
  localparam int WW = $clog2(WAYS);

  always_comb begin
    way_o = rr_i;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) way_o = WW'(i);
    end
  end

  assign free_o = ~&valid_i;
endmodule

// File: rtl/dcache_tag_ctrl.sv
module dcache_tag_ctrl
  import dct_pkg::*;
#(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW     = $clog2(SETS),
  localparam int WW     = $clog2(WAYS),
  localparam int WSW    = $clog2(WORDS),
  localparam int OFF_W  = $clog2(WORDS * DW / 8),
  localparam int ADDR_W = TAG_W + IW + OFF_W,
  localparam int LINE_W = WORDS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all_i,
  output logic              busy_o,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WW-1:0]     req_way_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WW-1:0]     resp_way_o,
  output logic [DW-1:0]     resp_rdata_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_line_o
);
  typedef logic [WORDS-1:0][DW-1:0] line_t;

  // line storage: not reset, cleared only by the sweep
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0]            vld_q  [SETS];
  logic [WAYS-1:0]            mod_q  [SETS];
  logic [WW-1:0]              rr_q   [SETS];
  line_t [WAYS-1:0]           data_q [SETS];

  dct_op_e          op;
  logic [IW-1:0]    idx;
  logic [TAG_W-1:0] tag;
  logic [WSW-1:0]   wsel;
  logic [OFF_W-WSW-1:0] byte_unused;
  logic             accept;
  logic             sweep_busy;
  logic [IW-1:0]    sweep_idx;

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_vld, set_mod;
  logic [WW-1:0]              set_rr;
  line_t [WAYS-1:0]           set_data;

  logic          hit, vic_free;
  logic [WW-1:0] hit_way, vic_way, fill_way, src_way;

  assign op          = dct_op_e'(req_op_i);
  assign idx         = req_addr_i[OFF_W +: IW];
  assign tag         = req_addr_i[OFF_W + IW +: TAG_W];
  assign wsel        = req_addr_i[OFF_W - WSW +: WSW];
  assign byte_unused = req_addr_i[OFF_W - WSW - 1:0];
  assign accept      = req_valid_i && !sweep_busy && !inv_all_i;

  assign set_tags = tag_q[idx];
  assign set_vld  = vld_q[idx];
  assign set_mod  = mod_q[idx];
  assign set_rr   = rr_q[idx];
  assign set_data = data_q[idx];

  dct_sweep #(.SETS(SETS)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (inv_all_i),
    .busy_o  (sweep_busy),
    .idx_o   (sweep_idx)
  );

  dct_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i  (set_tags),
    .valid_i (set_vld),
    .tag_i   (tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  dct_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (set_vld),
    .rr_i    (set_rr),
    .free_o  (vic_free),
    .way_o   (vic_way)
  );

  assign fill_way = hit ? hit_way : vic_way;
  assign src_way  = (op == OP_PUSH) ? req_way_i : vic_way;

  // array updates
  always_ff @(posedge clk) begin
    if (sweep_busy) begin
      vld_q[sweep_idx] <= '0;
      mod_q[sweep_idx] <= '0;
      rr_q[sweep_idx]  <= '0;
    end else if (accept) begin
      case (op)
        OP_WRITE: if (hit) begin
          data_q[idx][hit_way][wsel] <= req_wdata_i;
          mod_q[idx][hit_way]        <= 1'b1;
        end
        OP_FILL: begin
          tag_q[idx][fill_way]  <= tag;
          data_q[idx][fill_way] <= req_line_i;
          vld_q[idx][fill_way]  <= 1'b1;
          mod_q[idx][fill_way]  <= 1'b0;
          if (!hit && !vic_free) rr_q[idx] <= set_rr + WW'(1);
        end
        OP_PUSH: begin
          vld_q[idx][req_way_i] <= 1'b0;
          mod_q[idx][req_way_i] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // response and write-back registers
  logic              rv_d, rh_d, wv_d;
  logic [WW-1:0]     rw_d;
  logic [DW-1:0]     rd_d;
  logic [ADDR_W-1:0] wa_d;
  logic [LINE_W-1:0] wl_d;
  logic              rv_q, rh_q, wv_q;
  logic [WW-1:0]     rw_q;
  logic [DW-1:0]     rd_q;
  logic [ADDR_W-1:0] wa_q;
  logic [LINE_W-1:0] wl_q;

  always_comb begin
    rv_d = accept;
    rh_d = hit;
    rw_d = hit_way;
    rd_d = set_data[hit_way][wsel];
    wv_d = 1'b0;
    wa_d = {set_tags[src_way], idx, {OFF_W{1'b0}}};
    wl_d = set_data[src_way];
    if (accept) begin
      case (op)
        OP_FILL: begin
          rw_d = fill_way;
          wv_d = !hit && set_vld[vic_way] && set_mod[vic_way];
        end
        OP_PUSH: begin
          rh_d = set_vld[req_way_i];
          rw_d = req_way_i;
          wv_d = set_vld[req_way_i] && set_mod[req_way_i];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rw_q <= '0;
      rd_q <= '0;
      wv_q <= 1'b0;
      wa_q <= '0;
      wl_q <= '0;
    end else begin
      rv_q <= rv_d;
      wv_q <= wv_d;
      if (accept) begin
        rh_q <= rh_d;
        rw_q <= rw_d;
        rd_q <= rd_d;
      end
      if (wv_d) begin
        wa_q <= wa_d;
        wl_q <= wl_d;
      end
    end
  end

  assign busy_o       = sweep_busy;
  assign resp_valid_o = rv_q;
  assign resp_hit_o   = rh_q;
  assign resp_way_o   = rw_q;
  assign resp_rdata_o = rd_q;
  assign wb_valid_o   = wv_q;
  assign wb_addr_o    = wa_q;
  assign wb_line_o    = wl_q;

  // R3: each accepted request is answered on the next cycle
  a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rv_q);
  // R2: nothing comes out for a request seen during the sweep
  a_r2_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |=> (!rv_q && !wv_q));
  // R7: a write-back only follows a fill or a push
  a_r7_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> $past(accept && (op == OP_FILL || op == OP_PUSH)));
  // R5: a set with room never evicts a valid line
  a_r5_fill_empty_way: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FILL && !hit && vic_free) |-> !set_vld[vic_way]);
  // R8: pushing a clean or invalid line writes nothing back
  a_r8_push_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_PUSH && !(set_vld[req_way_i] && set_mod[req_way_i]))
      |=> !wv_q);
endmodule

// File: tb/test_dcache_tag_ctrl.sv
module test_dcache_tag_ctrl;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int TW   = 21;
  localparam int IW   = 3;
  localparam int AW   = TW + IW + 4;
  localparam int LW   = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inv_all;
  logic          busy;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_way;
  logic [31:0]   req_wdata;
  logic [LW-1:0] req_line;
  logic          resp_valid, resp_hit;
  logic [1:0]    resp_way;
  logic [31:0]   resp_rdata;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [LW-1:0] wb_line;

  dcache_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TW), .WORDS(4), .DW(32)) i_dcache_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .inv_all_i(inv_all), .busy_o(busy),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_way_i(req_way), .req_wdata_i(req_wdata), .req_line_i(req_line),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_way_o(resp_way),
    .resp_rdata_o(resp_rdata), .wb_valid_o(wb_valid), .wb_addr_o(wb_addr),
    .wb_line_o(wb_line)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  bit            mv  [SETS][WAYS];
  bit            mm  [SETS][WAYS];
  logic [TW-1:0] mt  [SETS][WAYS];
  logic [LW-1:0] md  [SETS][WAYS];
  int            mrr [SETS];

  task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pat(input int s, input int k);
    logic [LW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = 32'(s * 32'h01000193 + k * 32'h9e37 + i * 32'h11);
    return r;
  endfunction

  // op: 0 read, 1 write, 2 fill, 3 push
  task automatic run(input int o, input logic [TW-1:0] tg, input int s, input int ws,
                     input int way, input logic [31:0] wd, input logic [LW-1:0] ln, input string rq);
    int h = -1;
    int w;
    bit wbe = 0;
    logic [AW-1:0] wbaddr = '0;
    logic [LW-1:0] wbl = '0;
    for (int k = 0; k < WAYS; k++) if (h < 0 && mv[s][k] && mt[s][k] == tg) h = k;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(o); req_addr = {tg, IW'(s), 2'(ws), 2'b00};
    req_way = 2'(way); req_wdata = wd; req_line = ln;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " resp_valid"}, LW'(resp_valid), 1);
    case (o)
      0, 1: begin
        chk({rq, " hit"}, LW'(resp_hit), LW'(h >= 0));
        if (h >= 0) begin
          chk({rq, " way"}, LW'(resp_way), LW'(h));
          if (o == 0) chk({rq, " rdata"}, LW'(resp_rdata), LW'(md[s][h][ws*32 +: 32]));
          else begin md[s][h][ws*32 +: 32] = wd; mm[s][h] = 1; end
        end
        chk({rq, " no wb"}, LW'(wb_valid), 0);
      end
      2: begin
        w = -1;
        if (h >= 0) w = h;
        else for (int k = WAYS - 1; k >= 0; k--) if (!mv[s][k]) w = k;
        if (w < 0) begin
          w = mrr[s]; mrr[s] = (mrr[s] + 1) % WAYS;
          wbe = mm[s][w];
          wbaddr = {mt[s][w], IW'(s), 4'b0000};
          wbl = md[s][w];
        end
        chk({rq, " fill hit"}, LW'(resp_hit), LW'(h >= 0));
        chk({rq, " fill way"}, LW'(resp_way), LW'(w));
        chk({rq, " wb_valid"}, LW'(wb_valid), LW'(wbe));
        if (wbe) begin
          chk({rq, " wb_addr"}, LW'(wb_addr), LW'(wbaddr));
          chk({rq, " wb_line"}, wb_line, wbl);
        end
        mv[s][w] = 1; mm[s][w] = 0; mt[s][w] = tg; md[s][w] = ln;
      end
      default: begin
        wbe = mv[s][way] && mm[s][way];
        chk({rq, " push hit"}, LW'(resp_hit), LW'(mv[s][way]));
        chk({rq, " push wb"}, LW'(wb_valid), LW'(wbe));
        if (wbe) begin
          chk({rq, " push wb_addr"}, LW'(wb_addr), LW'({mt[s][way], IW'(s), 4'b0000}));
          chk({rq, " push wb_line"}, wb_line, md[s][way]);
        end
        mv[s][way] = 0; mm[s][way] = 0;
      end
    endcase
  endtask

  task automatic sweep(input string rq);
    int cnt = 0;
    bit quiet = 1;
    @(negedge clk);
    inv_all = 1'b1; req_valid = 1'b1; req_op = 2'd2;   // fill issued with the command: ignored
    req_addr = '0; req_line = '1;
    @(negedge clk);
    inv_all = 1'b0; req_op = 2'd0;                     // reads issued during the sweep
    while (busy && cnt < 4 * SETS) begin
      cnt++;
      if (resp_valid || wb_valid) quiet = 0;
      @(negedge clk);
    end
    if (resp_valid || wb_valid) quiet = 0;
    req_valid = 1'b0;
    chk({rq, " busy cycles"}, LW'(cnt), LW'(SETS));
    chk("R2 ignored during sweep", LW'(quiet), 1);
    for (int s = 0; s < SETS; s++) begin
      mrr[s] = 0;
      for (int k = 0; k < WAYS; k++) begin mv[s][k] = 0; mm[s][k] = 0; end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inv_all = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_way = '0; req_wdata = '0; req_line = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", LW'(busy), 0);
    chk("R11 resp_valid after reset", LW'(resp_valid), 0);
    chk("R11 wb_valid after reset", LW'(wb_valid), 0);
    rst_n = 1'b1;

    sweep("R1");
    for (int s = 0; s < SETS; s++) run(0, TW'(s + 5), s, 0, 0, 0, '0, "R1 miss after sweep");

    // exhaustive first fills and reads: R5, R3
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) run(2, TW'(s * 16 + k + 1), s, 0, 0, 0, pat(s, k), "R5");
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++)
        for (int ws = 0; ws < 4; ws++) run(0, TW'(s * 16 + k + 1), s, ws, 0, 0, '0, "R3");

    // writes: one hit per set, one miss per set (R4)
    for (int s = 0; s < SETS; s++) begin
      run(1, TW'(s * 16 + (s % 4) + 1), s, s % 4, 0, 32'hA5A5_0000 + 32'(s), '0, "R4 write hit");
      run(0, TW'(s * 16 + (s % 4) + 1), s, s % 4, 0, 0, '0, "R4 readback");
      run(1, TW'(12'hFFF), s, 1, 0, 32'hDEAD_BEEF, '0, "R4 write miss");
      for (int k = 0; k < WAYS; k++) run(0, TW'(s * 16 + k + 1), s, 1, 0, 0, '0, "R4 unchanged");
    end

    // replacement through a full turn of the pointer (R6, R7)
    for (int s = 0; s < SETS; s++)
      for (int n = 0; n < 5; n++) run(2, TW'(1000 + s * 8 + n), s, 0, 0, 0, pat(s, 10 + n), "R6 R7");

    // refill of a present, modified line (R9)
    run(1, TW'(1000 + 8 * 2 + 4), 2, 3, 0, 32'h1234_5678, '0, "R9 prep");
    run(2, TW'(1000 + 8 * 2 + 4), 2, 0, 0, 0, pat(2, 40), "R9");
    run(0, TW'(1000 + 8 * 2 + 4), 2, 3, 0, 0, '0, "R9 readback");

    // pushes (R8, R10)
    run(1, mt[3][1], 3, 2, 0, 32'hCAFE_0001, '0, "R8 prep");
    run(3, mt[3][1], 3, 0, 1, 0, '0, "R8 dirty push");
    run(0, mt[3][1] ^ TW'(0), 3, 2, 0, 0, '0, "R10 pushed line misses");
    run(3, mt[3][2], 3, 0, 2, 0, '0, "R8 clean push");
    run(3, mt[3][1], 3, 0, 1, 0, '0, "R8 invalid push");
    run(2, TW'(77), 3, 0, 0, 0, pat(3, 77), "R5 reuse lowest freed way");

    // reset keeps contents (R11)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 busy in reset", LW'(busy), 0);
    chk("R11 resp_valid in reset", LW'(resp_valid), 0);
    rst_n = 1'b1;
    run(0, TW'(77), 3, 1, 0, 0, '0, "R11 retained");

    sweep("R1 second");
    run(0, TW'(77), 3, 1, 0, 0, '0, "R1 R10 cleared");
    run(2, TW'(90), 3, 0, 0, 0, pat(3, 90), "R1 R5 way0 after sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule